// File: doc/BRIEF.md
# MDIO Management Register Engine

This block lets software reach the management registers of an Ethernet PHY through four small registers. Software loads a write-data register, then writes a command word holding a request bit (read or write), a 5-bit PHY address and a 5-bit register number. The engine sends one clause-22 management frame on MDC/MDIO and clears the request bit when the frame ends. For a read, the 16 returned bits are placed in a read-data register. Software polls the command word until the request bit is clear.

A frame is a preamble of 32 ones, the start pattern 01, an opcode (10 for read, 01 for write), the PHY address, the register number, a two-bit turnaround and 16 data bits. Every field is sent MSB first. MDC is produced from the system clock by a programmable divider. Each MDC half period lasts divider+1 clock cycles, so one frame takes 128*(divider+1) cycles. With the default divider that is 1024 cycles, well under a 2048-poll software timeout.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset the command and read-data registers read 0, the divider reads DIV_INIT (7), MDC is low and MDIO is not driven.
- R2: A write request (command bit 14) sends 64 bits, sampled on rising MDC edges, in this order: 32 ones, 01, 01, PHY address, register number, 10, then the write-data register contents.
- R3: A read request (command bit 13) drives the first 46 bits: 32 ones, 01, 10, PHY address, register number. It then releases MDIO from the first turnaround bit until the frame ends. A write never releases MDIO while busy.
- R4: On a read, MDIO is sampled on the 16 rising MDC edges of the data field, MSB first, and the result goes into the read-data register when the frame ends. A write transaction leaves the read-data register unchanged.
- R5: The request bit reads 1 from the command write until the frame completes and then clears itself. The busy time is exactly 128*(divider+1) clock cycles.
- R6: While idle, MDC stays low and MDIO is not driven. A command word with neither request bit set starts no frame.
- R7: A command write while busy is ignored. The command readback, the frame on the wire and the completion time are unaffected, and no second frame follows.
- R8: A divider write while busy is ignored.
- R9: A command with both request bits set is carried out as a write.
- R10: Register map by address: 0 command, 1 write data, 2 read data (read-only), 3 divider. The command reads back as request bits 14:13, PHY address 12:8 and register number 4:0; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Register read value for reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven to the PHY |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data from the PHY |

## Verification
A bad bit counter or divider counter appears at the ports within one frame. The request bit clears at the wrong cycle count, the bit stream captured on rising MDC edges is shifted, or MDIO is released at the wrong bit. A wrong latched opcode or address appears in the captured header in the first 46 MDC periods. A bad receive path only shows up in the read-data register at the end of the frame. A lost busy guard lets a second command change the command readback at once and corrupt the frame in progress.

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine #(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 7,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TA_BIT   = CNT_W'(PRE_LEN + 14);
  localparam logic [CNT_W-1:0] DAT_BIT  = CNT_W'(PRE_LEN + 16);
  localparam logic [CNT_W-1:0] BODY_BIT = CNT_W'(PRE_LEN);

  logic [1:0]       req_q;
  logic [4:0]       phy_q, reg_q;
  logic [15:0]      wdata_q, tx_data_q, rdata_q, rx_sh;
  logic [DIV_W-1:0] div_q, div_cnt;
  logic [CNT_W-1:0] bit_cnt, rel;
  logic             half_q;

  logic busy, is_wr, tick, last, in_rx, data_ph, cmd_wr, bit_val;
  logic [31:0] body;
  logic [4:0]  body_idx;
  logic        unused_bits;

  assign busy     = |req_q;
  assign is_wr    = req_q[1];
  assign tick     = (div_cnt == div_q);
  assign last     = (bit_cnt == LAST_BIT);
  assign in_rx    = !is_wr && (bit_cnt >= TA_BIT);
  assign data_ph  = (bit_cnt >= DAT_BIT);
  assign cmd_wr   = reg_wr && (reg_addr == 2'd0) && !busy;
  assign body     = {2'b01, is_wr ? 2'b01 : 2'b10, phy_q, reg_q, 2'b10,
                     is_wr ? tx_data_q : 16'hFFFF};
  assign rel      = bit_cnt - BODY_BIT;
  assign body_idx = 5'd31 - rel[4:0];
  assign bit_val  = (bit_cnt < BODY_BIT) ? 1'b1 : body[body_idx];

  assign mdc         = half_q;
  assign mdio_oe     = busy && !in_rx;
  assign mdio_o      = mdio_oe && bit_val;
  assign unused_bits = ^{reg_wdata[15], reg_wdata[7:5]};

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {1'b0, req_q, phy_q, 3'b000, reg_q};
      2'd1:    reg_rdata = wdata_q;
      2'd2:    reg_rdata = rdata_q;
      default: reg_rdata = 16'(div_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      div_q   <= DIV_W'(DIV_INIT);
    end else if (reg_wr) begin
      if (reg_addr == 2'd1) wdata_q <= reg_wdata;
      if (reg_addr == 2'd3 && !busy) div_q <= reg_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= '0;
      phy_q     <= '0;
      reg_q     <= '0;
      tx_data_q <= '0;
      rdata_q   <= '0;
      rx_sh     <= '0;
      div_cnt   <= '0;
      bit_cnt   <= '0;
      half_q    <= 1'b0;
    end else if (cmd_wr) begin
      req_q     <= reg_wdata[14:13];
      phy_q     <= reg_wdata[12:8];
      reg_q     <= reg_wdata[4:0];
      tx_data_q <= wdata_q;
      div_cnt   <= '0;
      bit_cnt   <= '0;
      half_q    <= 1'b0;
    end else if (busy) begin
      if (!tick) begin
        div_cnt <= div_cnt + 1'b1;
      end else begin
        div_cnt <= '0;
        if (!half_q) begin
          half_q <= 1'b1;
          if (!is_wr && data_ph) rx_sh <= {rx_sh[14:0], mdio_i};
        end else begin
          half_q <= 1'b0;
          if (last) begin
            req_q   <= '0;
            bit_cnt <= '0;
            if (!is_wr) rdata_q <= rx_sh;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

module mdio_mgmt_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [1:0]       req,
  input logic [9:0]       fields,
  input logic [DIV_W-1:0] div,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe
);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
  // R5
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!mdc && $past(mdc)));
  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(fields) && $stable(req)));
  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div));
  // R2
  data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
  // R3
  write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req[1]) |-> mdio_oe);
  // R3
  release_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |=> !mdio_oe);
endmodule

bind mdio_mgmt_engine mdio_mgmt_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req(req_q),
  .fields({phy_q, reg_q}), .div(div_q), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_engine_tb.sv
module mdio_mgmt_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  mdio_mgmt_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0, rise_n = 0, cap_n = 0;
  logic [63:0] cap = '0;
  logic [15:0] rsp_q = '0;

  always @(posedge clk) cycles++;

  always @(posedge mdc) begin
    if (mdio_oe) begin
      cap = {cap[62:0], mdio_o};
      cap_n++;
    end
    rise_n++;
    mdio_i = (rise_n >= 48 && rise_n < 64) ? rsp_q[63 - rise_n] : 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; #1 d = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic arm(input logic [15:0] rsp);
    rsp_q = rsp; rise_n = 0; cap_n = 0; cap = '0; mdio_i = 1'b1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    #1;
    while ((reg_rdata[14] | reg_rdata[13]) && n < 5000) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  // {is_write, phy, reg, wdata, phy response, divider}
  localparam logic [50:0] VEC [0:5] = '{
    {1'b1, 5'd1,  5'd0,  16'h1234, 16'h0000, 8'd0},
    {1'b0, 5'd30, 5'd17, 16'h0000, 16'hA5C3, 8'd0},
    {1'b1, 5'd0,  5'd31, 16'hFFFF, 16'h0000, 8'd1},
    {1'b0, 5'd31, 5'd2,  16'h0000, 16'h0001, 8'd3},
    {1'b1, 5'd17, 5'd19, 16'h8001, 16'h0000, 8'd2},
    {1'b0, 5'd5,  5'd30, 16'h0000, 16'hFFFE, 8'd7}
  };

  initial begin
    logic [15:0] v, last_rd;
    int n;
    last_rd = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk(v == 16'h0000, "R1 cmd", 64'(v), 64'h0);
    rd(2'd2, v); chk(v == 16'h0000, "R1 rdata", 64'(v), 64'h0);
    rd(2'd3, v); chk(v == 16'd7, "R1 div", 64'(v), 64'd7);
    chk(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 64'h0);

    // R10 readback / R6 no request bits
    arm(16'h0);
    wr(2'd0, 16'h9FFF);
    rd(2'd0, v); chk(v == 16'h1F1F, "R10 cmd readback", 64'(v), 64'h1F1F);
    repeat (40) @(negedge clk);
    chk(!mdc && !mdio_oe && cap_n == 0 && rise_n == 0, "R6 no frame", 64'(rise_n), 64'h0);
    wr(2'd1, 16'hBEEF);
    rd(2'd1, v); chk(v == 16'hBEEF, "R10 wdata", 64'(v), 64'hBEEF);

    for (int i = 0; i < 6; i++) begin
      logic iw; logic [4:0] ph, rg; logic [15:0] wd, rs; logic [7:0] dv;
      {iw, ph, rg, wd, rs, dv} = VEC[i];
      wr(2'd3, 16'(dv));
      wr(2'd1, wd);
      arm(rs);
      @(negedge clk);
      reg_addr = 2'd0; reg_wdata = (iw ? 16'h4000 : 16'h2000) | {3'b0, ph, 8'h00} | 16'(rg);
      reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      wait_idle(n);
      chk(n == 128 * (int'(dv) + 1), "R5 busy cycles", 64'(n), 64'(128 * (int'(dv) + 1)));
      if (iw) begin
        chk(cap_n == 64 && cap == {32'hFFFF_FFFF, 2'b01, 2'b01, ph, rg, 2'b10, wd},
            "R2 write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, ph, rg, 2'b10, wd});
        rd(2'd2, v); chk(v == last_rd, "R4 rdata kept", 64'(v), 64'(last_rd));
      end else begin
        chk(cap_n == 46 && cap[45:0] == {32'hFFFF_FFFF, 2'b01, 2'b10, ph, rg},
            "R3 read header", cap, {18'h0, 32'hFFFF_FFFF, 2'b01, 2'b10, ph, rg});
        rd(2'd2, v); chk(v == rs, "R4 rdata", 64'(v), 64'(rs));
        last_rd = rs;
      end
      chk(!mdc && !mdio_oe, "R6 idle after", {mdc, mdio_oe}, 64'h0);
    end

    // R9 both request bits -> write
    wr(2'd3, 16'd0);
    wr(2'd1, 16'h5A5A);
    arm(16'h0);
    wr(2'd0, 16'h6000 | 16'h0300 | 16'h0004);
    wait_idle(n);
    chk(cap_n == 64 && cap == {32'hFFFF_FFFF, 4'b0101, 5'd3, 5'd4, 2'b10, 16'h5A5A},
        "R9 both bits write", cap, {32'hFFFF_FFFF, 4'b0101, 5'd3, 5'd4, 2'b10, 16'h5A5A});

    // R7 / R8 writes while busy
    wr(2'd3, 16'd1);
    wr(2'd1, 16'hC001);
    arm(16'h0);
    wr(2'd0, 16'h4000 | 16'h0900 | 16'h0006);
    repeat (10) @(negedge clk);
    wr(2'd0, 16'h2000 | 16'h1F00 | 16'h001F);
    wr(2'd3, 16'd5);
    rd(2'd0, v); chk(v == 16'h4906, "R7 cmd unchanged", 64'(v), 64'h4906);
    rd(2'd3, v); chk(v == 16'd1, "R8 div unchanged", 64'(v), 64'd1);
    wait_idle(n);
    chk(cap_n == 64 && cap == {32'hFFFF_FFFF, 4'b0101, 5'd9, 5'd6, 2'b10, 16'hC001},
        "R7 frame intact", cap, {32'hFFFF_FFFF, 4'b0101, 5'd9, 5'd6, 2'b10, 16'hC001});
    n = rise_n;
    repeat (60) @(negedge clk);
    chk(rise_n == n && !mdc, "R7 no second frame", 64'(rise_n), 64'(n));
    rd(2'd0, v); chk(v == 16'h0906, "R5 request cleared", 64'(v), 64'h0906);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule